// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the program/erase engine of a NOR-style flash array. Every host write arrives as a single-clock strobe with an address and data word already captured. The block tracks multi-write unlock sequences and turns each completed sequence into one operation request for the array engine. A request carries its kind, its target address and data, and, for sector erase, a mask of the sectors collected. The block also reports which mode the device is in, so that the read path can choose what to return: array data, identification codes, fast-program mode or erase-suspended reads.

The key addresses that make up a sequence move with the bus width. In word mode they sit on the low eleven address bits. In byte mode the extra least significant address bit shifts them up by one place. Address bits above the key field are ignored, except where a write carries a program, sector or bank address. A temporary fast mode shortens programming to two writes. While the array engine reports busy, the decoder only listens for suspend, reset and resume.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode_o` is 0 (read), `op_valid` is low, `op_kind` is 0 (none) and `erase_mask` is all zero.
- R2: In word mode (`byte_mode`=0) the first key address is 0x555 and the second is 0x2AA, both compared on `wr_addr[10:0]`. In byte mode the first key is 0xAAA and the second is 0x555, both compared on `wr_addr[11:0]`. Higher address bits never affect a key match.
- R3: The write sequence 0xAA at key 1, 0x55 at key 2, 0xA0 at key 1, then any address/data produces `op_kind`=1 (program). `op_addr` and `op_data` take the address and data of the last write. The request appears in the cycle after the clock edge that samples that write.
- R4: A single write of 0xF0 to any address, or 0xAA, 0x55, 0xF0 at the key addresses, sets `mode_o` to 0 and issues no request.
- R5: The sequence 0xAA, 0x55, then 0x90 at key 1 sets `mode_o` to 1 (identification). In that mode further unlock sequences are still decoded.
- R6: The six writes 0xAA, 0x55, 0x80, 0xAA, 0x55 at the alternating keys, followed by 0x10 at key 1, produce `op_kind`=2 (chip erase).
- R7: The same five-write prefix followed by 0x30 at any address opens a sector window. The sector index is `wr_addr[19:16]` in byte mode and `wr_addr[18:15]` in word mode. Each further 0x30 write adds its sector to the window and restarts it. The request `op_kind`=3 appears exactly `WIN_CYC` cycles after the edge of the last accepted 0x30 write. It carries `erase_mask` with one bit per collected sector and `op_addr` equal to the first sector's address.
- R8: A write that does not fit the expected step of a sequence aborts it. No request is issued, `mode_o` returns to 0, and an open sector window is discarded.
- R9: While an erase is in progress, a write of 0xB0 produces `op_kind`=4 (suspend) and `mode_o`=3. An erase is in progress from its request until `busy` falls outside suspend. In suspend, only 0x30 has an effect: it produces `op_kind`=5 (resume) and sets `mode_o` to 0. Once the erase is over, 0xB0 is an ordinary aborting write.
- R10: The sequence 0xAA, 0x55, then 0x20 at key 1 sets `mode_o`=2 (fast). In fast mode, 0xA0 followed by an address/data write produces `op_kind`=1, and 0x90 followed by 0xF0 returns `mode_o` to 0.
- R11: While `busy` is high, every write other than 0xB0, 0xF0, or 0x30 in suspend leaves the decoder state unchanged and issues no request.
- R12: `op_valid` is a one-cycle pulse per request, and `op_kind` reads 0 whenever `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Captured write address (byte address in byte mode, word address in word mode) |
| wr_data | input | DATA_W | Captured write data; command code in bits 7:0 |
| byte_mode | input | 1 | 1 selects byte-wide bus addressing |
| busy | input | 1 | Array engine is executing a program or erase |
| op_valid | output | 1 | Operation request pulse |
| op_kind | output | 3 | 0 none, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Target address of the request |
| op_data | output | DATA_W | Program data of the request |
| erase_mask | output | 2**SECT_W | Sectors selected by the latest sector-erase request |
| mode_o | output | 2 | 0 read, 1 identification, 2 fast, 3 erase suspended |

## Verification
The checker covers the invariants that hold in every cycle:
- `op_kind` stays idle between pulses.
- A program request only follows a sampled write.
- A suspend request always lands in suspended mode.
- Fast mode only ever emits program requests.
- A sector-erase request never carries an empty mask.
- Busy-time writes other than suspend never produce a request.

The bench scenarios cover the rest. These are the grammar itself in both bus widths, don't-care high address bits, aborts that poison later writes, the exact expiry cycle of the sector window and its restart, and the full erase, suspend, resume and completion cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_FAST    = 2'd2,
        MODE_SUSP    = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_SECT   = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3,
        SQ_WIN,
        SQ_FIDLE,
        SQ_FPROG,
        SQ_FEXIT
    } seq_e;

    localparam logic [7:0] C_UNLOCK_A = 8'hAA;
    localparam logic [7:0] C_UNLOCK_B = 8'h55;
    localparam logic [7:0] C_PROGRAM  = 8'hA0;
    localparam logic [7:0] C_ERASE    = 8'h80;
    localparam logic [7:0] C_IDENT    = 8'h90;
    localparam logic [7:0] C_RESET    = 8'hF0;
    localparam logic [7:0] C_CHIP     = 8'h10;
    localparam logic [7:0] C_SECTOR   = 8'h30;
    localparam logic [7:0] C_SUSPEND  = 8'hB0;
    localparam logic [7:0] C_FAST     = 8'h20;

endpackage

// File: rtl/flash_addr_decode.sv
module flash_addr_decode #(
    parameter int KEY_W  = 11,
    parameter int SECT_W = 4
) (
    input  logic [KEY_W:0]    key_bits,
    input  logic [SECT_W:0]   sect_bits,
    input  logic              byte_mode,
    output logic              is_key1,
    output logic              is_key2,
    output logic [SECT_W-1:0] sect_idx
);
    localparam logic [KEY_W-1:0] WORD_K1 = KEY_W'(11'h555);
    localparam logic [KEY_W-1:0] WORD_K2 = KEY_W'(11'h2AA);
    localparam logic [KEY_W:0]   BYTE_K1 = {WORD_K1, 1'b0};
    localparam logic [KEY_W:0]   BYTE_K2 = {WORD_K2, 1'b1};

    always_comb begin
        if (byte_mode) begin
            is_key1  = (key_bits == BYTE_K1);
            is_key2  = (key_bits == BYTE_K2);
            sect_idx = sect_bits[SECT_W:1];
        end else begin
            is_key1  = (key_bits[KEY_W-1:0] == WORD_K1);
            is_key2  = (key_bits[KEY_W-1:0] == WORD_K2);
            sect_idx = sect_bits[SECT_W-1:0];
        end
    end
endmodule

// File: rtl/flash_sector_queue.sv
module flash_sector_queue #(
    parameter int SECT_W  = 4,
    parameter int WIN_CYC = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   add,
    input  logic                   clear,
    input  logic [SECT_W-1:0]      sect,
    output logic [(1<<SECT_W)-1:0] mask,
    output logic                   expire
);
    localparam int NSECT = 1 << SECT_W;
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC - 1);

    typedef struct packed {
        logic [NSECT-1:0] mask;
        logic [CNT_W-1:0] cnt;
        logic             act;
    } qstate_t;

    qstate_t q, d;
    logic [NSECT-1:0] sel;

    for (genvar i = 0; i < NSECT; i++) begin : g_sel
        assign sel[i] = (sect == SECT_W'(i));
    end

    always_comb begin
        d      = q;
        expire = 1'b0;
        if (clear) begin
            d.mask = '0;
            d.act  = 1'b0;
        end else if (start) begin
            d.mask = sel;
            d.act  = 1'b1;
            d.cnt  = CNT_LOAD;
        end else if (add) begin
            d.mask = q.mask | sel;
            d.cnt  = CNT_LOAD;
        end else if (q.act) begin
            if (q.cnt == '0) begin
                expire = 1'b1;
                d.act  = 1'b0;
                d.mask = '0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mask = q.mask;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    parameter int KEY_W   = 11,
    parameter int SECT_W  = 4,
    parameter int WIN_CYC = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   byte_mode,
    input  logic                   busy,
    output logic                   op_valid,
    output logic [2:0]             op_kind,
    output logic [ADDR_W-1:0]      op_addr,
    output logic [DATA_W-1:0]      op_data,
    output logic [(1<<SECT_W)-1:0] erase_mask,
    output logic [1:0]             mode_o
);
    localparam int NSECT = 1 << SECT_W;

    typedef struct packed {
        seq_e              seq;
        mode_e             mode;
        logic              erase_act;
        logic              busy_d1;
        logic              op_valid;
        op_e               op_kind;
        logic [ADDR_W-1:0] op_addr;
        logic [DATA_W-1:0] op_data;
        logic [NSECT-1:0]  op_mask;
        logic [ADDR_W-1:0] first_addr;
    } dec_t;

    dec_t q, d;

    logic              is_key1, is_key2;
    logic [SECT_W-1:0] sect_idx;
    logic              q_start, q_add, q_clear, q_expire;
    logic [NSECT-1:0]  q_mask;
    logic [7:0]        cmd;

    assign cmd = wr_data[7:0];

    flash_addr_decode #(.KEY_W(KEY_W), .SECT_W(SECT_W)) u_dec (
        .key_bits (wr_addr[KEY_W:0]),
        .sect_bits(wr_addr[ADDR_W-1 -: SECT_W+1]),
        .byte_mode(byte_mode),
        .is_key1  (is_key1),
        .is_key2  (is_key2),
        .sect_idx (sect_idx)
    );

    flash_sector_queue #(.SECT_W(SECT_W), .WIN_CYC(WIN_CYC)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q_start),
        .add   (q_add),
        .clear (q_clear),
        .sect  (sect_idx),
        .mask  (q_mask),
        .expire(q_expire)
    );

    always_comb begin
        d          = q;
        d.op_valid = 1'b0;
        d.op_kind  = OP_NONE;
        d.busy_d1  = busy;
        q_start    = 1'b0;
        q_add      = 1'b0;
        q_clear    = 1'b0;

        // erase completion: engine drops busy outside suspend
        if (q.busy_d1 && !busy && q.mode != MODE_SUSP) d.erase_act = 1'b0;

        if (q_expire) begin
            d.op_valid  = 1'b1;
            d.op_kind   = OP_SECT;
            d.op_addr   = q.first_addr;
            d.op_mask   = q_mask;
            d.erase_act = 1'b1;
            d.seq       = SQ_IDLE;
        end

        if (wr_stb) begin
            if (q.mode == MODE_SUSP) begin
                if (cmd == C_SECTOR) begin
                    d.op_valid = 1'b1;
                    d.op_kind  = OP_RESUME;
                    d.mode     = MODE_READ;
                    d.seq      = SQ_IDLE;
                end
            end else if (busy && cmd != C_SUSPEND && cmd != C_RESET) begin
                d.seq = q.seq;
            end else begin
                case (q.seq)
                    SQ_PROG, SQ_FPROG: begin
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_PROG;
                        d.op_addr  = wr_addr;
                        d.op_data  = wr_data;
                        d.seq      = (q.seq == SQ_FPROG) ? SQ_FIDLE : SQ_IDLE;
                        if (q.seq == SQ_PROG) d.mode = MODE_READ;
                    end
                    SQ_FIDLE: begin
                        if (cmd == C_PROGRAM)    d.seq = SQ_FPROG;
                        else if (cmd == C_IDENT) d.seq = SQ_FEXIT;
                    end
                    SQ_FEXIT: begin
                        if (cmd == C_RESET) begin
                            d.mode = MODE_READ;
                            d.seq  = SQ_IDLE;
                        end else begin
                            d.seq = SQ_FIDLE;
                        end
                    end
                    default: begin
                        // abort path is the default outcome of every step
                        d.seq   = SQ_IDLE;
                        d.mode  = MODE_READ;
                        q_clear = (q.seq == SQ_WIN);
                        if (cmd == C_RESET) begin
                            d.seq = SQ_IDLE;
                        end else if (cmd == C_SUSPEND && q.erase_act) begin
                            d.op_valid = 1'b1;
                            d.op_kind  = OP_SUSP;
                            d.op_addr  = wr_addr;
                            d.mode     = MODE_SUSP;
                        end else begin
                            case (q.seq)
                                SQ_IDLE: if (cmd == C_UNLOCK_A && is_key1) begin
                                    d.seq  = SQ_UNL1;
                                    d.mode = q.mode;
                                end
                                SQ_UNL1: if (cmd == C_UNLOCK_B && is_key2) begin
                                    d.seq  = SQ_UNL2;
                                    d.mode = q.mode;
                                end
                                SQ_UNL2: if (is_key1) begin
                                    if (cmd == C_PROGRAM) begin
                                        d.seq  = SQ_PROG;
                                        d.mode = q.mode;
                                    end else if (cmd == C_IDENT) begin
                                        d.mode = MODE_AUTOSEL;
                                    end else if (cmd == C_ERASE) begin
                                        d.seq  = SQ_ERA1;
                                        d.mode = q.mode;
                                    end else if (cmd == C_FAST) begin
                                        d.seq  = SQ_FIDLE;
                                        d.mode = MODE_FAST;
                                    end
                                end
                                SQ_ERA1: if (cmd == C_UNLOCK_A && is_key1) begin
                                    d.seq  = SQ_ERA2;
                                    d.mode = q.mode;
                                end
                                SQ_ERA2: if (cmd == C_UNLOCK_B && is_key2) begin
                                    d.seq  = SQ_ERA3;
                                    d.mode = q.mode;
                                end
                                SQ_ERA3: begin
                                    if (cmd == C_CHIP && is_key1) begin
                                        d.op_valid  = 1'b1;
                                        d.op_kind   = OP_CHIP;
                                        d.op_addr   = wr_addr;
                                        d.erase_act = 1'b1;
                                    end else if (cmd == C_SECTOR) begin
                                        q_start      = 1'b1;
                                        d.first_addr = wr_addr;
                                        d.seq        = SQ_WIN;
                                        d.mode       = q.mode;
                                    end
                                end
                                SQ_WIN: if (cmd == C_SECTOR) begin
                                    q_add   = 1'b1;
                                    q_clear = 1'b0;
                                    d.seq   = SQ_WIN;
                                    d.mode  = q.mode;
                                end
                                default: d.seq = SQ_IDLE;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign op_valid   = q.op_valid;
    assign op_kind    = q.op_kind;
    assign op_addr    = q.op_addr;
    assign op_data    = q.op_data;
    assign erase_mask = q.op_mask;
    assign mode_o     = q.mode;
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
    import flash_cmd_pkg::*;
#(
    parameter int NSECT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic [7:0]       cmd,
    input logic             busy,
    input logic             op_valid,
    input logic [2:0]       op_kind,
    input logic [NSECT-1:0] erase_mask,
    input logic [1:0]       mode_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |-> (mode_o == 2'd0 && !op_valid));

    p_idle_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> op_kind == 3'd0);

    p_prog_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd1) |-> $past(wr_stb));

    p_suspend_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd4) |-> mode_o == 2'd3);

    p_fast_prog_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && mode_o == 2'd2) |-> op_kind == 3'd1);

    p_sector_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd3) |-> erase_mask != '0);

    p_busy_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && cmd != C_SUSPEND && mode_o != 2'd3) |=> !op_valid);
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.NSECT(1 << SECT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .cmd       (wr_data[7:0]),
    .busy      (busy),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .erase_mask(erase_mask),
    .mode_o    (mode_o)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int SECT_W  = 4;
    localparam int WIN_CYC = 16;
    localparam int NSECT   = 1 << SECT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic              wr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              byte_mode = 1'b0;
    logic              busy = 1'b0;
    logic              op_valid;
    logic [2:0]        op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [NSECT-1:0]  erase_mask;
    logic [1:0]        mode_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
                        .WIN_CYC(WIN_CYC)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .erase_mask(erase_mask), .mode_o(mode_o)
    );

    // vector: {byte_mode, addr, data, expected kind, expected mode}
    localparam int NV = 41;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 20'h00555, 16'h00AA, 3'd0, 2'd0},  // R3 word program
        {1'b0, 20'h002AA, 16'h0055, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h00A0, 3'd0, 2'd0},
        {1'b0, 20'h12345, 16'h1234, 3'd1, 2'd0},
        {1'b0, 20'h7F555, 16'h00AA, 3'd0, 2'd0},  // R2 high bits ignored
        {1'b0, 20'h012AA, 16'h0055, 3'd0, 2'd0},
        {1'b0, 20'h30555, 16'h00A0, 3'd0, 2'd0},
        {1'b0, 20'h01000, 16'h5A5A, 3'd1, 2'd0},
        {1'b1, 20'h00AAA, 16'h00AA, 3'd0, 2'd0},  // R2 byte keys
        {1'b1, 20'h00555, 16'h0055, 3'd0, 2'd0},
        {1'b1, 20'h00AAA, 16'h00A0, 3'd0, 2'd0},
        {1'b1, 20'h80001, 16'h00AB, 3'd1, 2'd0},
        {1'b0, 20'h00555, 16'h00AA, 3'd0, 2'd0},  // R5 identification
        {1'b0, 20'h002AA, 16'h0055, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h0090, 3'd0, 2'd1},
        {1'b0, 20'h0ABCD, 16'h00F0, 3'd0, 2'd0},  // R4 single reset
        {1'b0, 20'h00555, 16'h00AA, 3'd0, 2'd0},
        {1'b0, 20'h002AA, 16'h0055, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h0090, 3'd0, 2'd1},
        {1'b0, 20'h00555, 16'h00AA, 3'd0, 2'd1},  // R4 three-write reset
        {1'b0, 20'h002AA, 16'h0055, 3'd0, 2'd1},
        {1'b0, 20'h00555, 16'h00F0, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h00AA, 3'd0, 2'd0},  // R8 wrong second key
        {1'b0, 20'h00555, 16'h0055, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h00A0, 3'd0, 2'd0},
        {1'b0, 20'h00100, 16'h1111, 3'd0, 2'd0},
        {1'b1, 20'h00555, 16'h00AA, 3'd0, 2'd0},  // R2 word key in byte mode
        {1'b1, 20'h00555, 16'h0055, 3'd0, 2'd0},
        {1'b1, 20'h00AAA, 16'h00A0, 3'd0, 2'd0},
        {1'b1, 20'h00010, 16'h2222, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h00AA, 3'd0, 2'd0},  // R10 fast mode
        {1'b0, 20'h002AA, 16'h0055, 3'd0, 2'd0},
        {1'b0, 20'h00555, 16'h0020, 3'd0, 2'd2},
        {1'b0, 20'h00000, 16'h00A0, 3'd0, 2'd2},
        {1'b0, 20'h04000, 16'h7777, 3'd1, 2'd2},
        {1'b0, 20'h00010, 16'h00A0, 3'd0, 2'd2},
        {1'b0, 20'h00020, 16'h8888, 3'd1, 2'd2},
        {1'b0, 20'h00000, 16'h0090, 3'd0, 2'd2},
        {1'b0, 20'h00000, 16'h00F0, 3'd0, 2'd0},
        {1'b0, 20'h00000, 16'h00A0, 3'd0, 2'd0},
        {1'b0, 20'h00020, 16'h9999, 3'd0, 2'd0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic bm, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] dt);
        @(negedge clk);
        byte_mode = bm;
        wr_addr   = a;
        wr_data   = dt;
        wr_stb    = 1'b1;
        @(negedge clk);
        wr_stb    = 1'b0;
    endtask

    task automatic erase_prefix();
        wr(1'b0, 20'h00555, 16'h00AA);
        wr(1'b0, 20'h002AA, 16'h0055);
        wr(1'b0, 20'h00555, 16'h0080);
        wr(1'b0, 20'h00555, 16'h00AA);
        wr(1'b0, 20'h002AA, 16'h0055);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mode_o == 2'd0 && !op_valid && op_kind == 3'd0 && erase_mask == '0,
            "R1 reset state", {op_valid, op_kind, mode_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            wr(v[41], v[40:21], v[20:5]);
            chk(op_valid == (v[4:2] != 3'd0) && op_kind == v[4:2],
                $sformatf("R3/R6/R10 vector %0d op kind", i), op_kind, v[4:2]);
            chk(mode_o == v[1:0], $sformatf("R4/R5/R10 vector %0d mode", i),
                mode_o, v[1:0]);
        end

        // R3 address and data of the program request, R12 pulse width
        wr(1'b0, 20'h00555, 16'h00AA);
        wr(1'b0, 20'h002AA, 16'h0055);
        wr(1'b0, 20'h00555, 16'h00A0);
        wr(1'b0, 20'h2468A, 16'hBEEF);
        chk(op_valid && op_addr == 20'h2468A, "R3 program address", op_addr, 32'h2468A);
        chk(op_data == 16'hBEEF, "R3 program data", op_data, 32'hBEEF);
        @(negedge clk);
        chk(!op_valid && op_kind == 3'd0, "R12 single pulse", {op_valid, op_kind}, 0);

        // R6 chip erase
        erase_prefix();
        wr(1'b0, 20'h00555, 16'h0010);
        chk(op_valid && op_kind == 3'd2, "R6 chip erase", op_kind, 2);
        busy = 1'b1;

        // R11 busy: a full program sequence is ignored
        wr(1'b0, 20'h00555, 16'h00AA);
        wr(1'b0, 20'h002AA, 16'h0055);
        wr(1'b0, 20'h00555, 16'h00A0);
        wr(1'b0, 20'h00100, 16'h4321);
        chk(!op_valid && mode_o == 2'd0, "R11 busy ignores program", {op_valid, mode_o}, 0);

        // R9 suspend, writes in suspend, resume
        wr(1'b0, 20'h40000, 16'h00B0);
        chk(op_valid && op_kind == 3'd4 && mode_o == 2'd3, "R9 suspend",
            {op_kind, mode_o}, {3'd4, 2'd3});
        wr(1'b0, 20'h00555, 16'h00AA);
        chk(!op_valid && mode_o == 2'd3, "R9 write ignored in suspend", {op_valid, mode_o}, 3);
        wr(1'b0, 20'h40000, 16'h0030);
        chk(op_valid && op_kind == 3'd5 && mode_o == 2'd0, "R9 resume",
            {op_kind, mode_o}, {3'd5, 2'd0});

        // R9 erase finished: suspend code is now an ordinary write
        busy = 1'b0;
        repeat (2) @(negedge clk);
        wr(1'b0, 20'h40000, 16'h00B0);
        chk(!op_valid && mode_o == 2'd0, "R9 suspend after completion", {op_valid, mode_o}, 0);

        // R7 sector window with restart on each added sector
        erase_prefix();
        wr(1'b0, 20'h18000, 16'h0030);
        chk(!op_valid, "R7 window opened, no request yet", op_valid, 0);
        repeat (3) @(negedge clk);
        wr(1'b0, 20'h48000, 16'h0030);
        begin
            bit early;
            early = 1'b0;
            for (int k = 1; k < WIN_CYC; k++) begin
                @(negedge clk);
                if (op_valid) early = 1'b1;
            end
            chk(!early, "R7 no request before window expiry", early, 0);
        end
        @(negedge clk);
        chk(op_valid && op_kind == 3'd3, "R7 sector erase at expiry", op_kind, 3);
        chk(erase_mask == 16'h0208, "R7 sector mask", erase_mask, 32'h0208);
        chk(op_addr == 20'h18000, "R7 first sector address", op_addr, 32'h18000);
        busy = 1'b1;
        repeat (2) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);

        // R8 window broken by a foreign write
        erase_prefix();
        wr(1'b0, 20'h28000, 16'h0030);
        wr(1'b0, 20'h00000, 16'h0055);
        begin
            bit seen;
            seen = op_valid;
            for (int k = 0; k < WIN_CYC + 4; k++) begin
                @(negedge clk);
                if (op_valid) seen = 1'b1;
            end
            chk(!seen && mode_o == 2'd0, "R8 window discarded", {seen, mode_o}, 0);
        end

        finish_run();
    end
endmodule